// File: doc/BRIEF.md
# Z80 Bus Cycle Capture Front End

This block sits beside a Z80-style processor bus and turns its activity into a stream of capture records for a logic-analyzer sample memory. All bus lines are sampled by a fast system clock. They pass through a synchronizer, and edges are found digitally. A record is produced when a memory request or an I/O request ends. Each record packs a 4-bit status nibble, the 16-bit address and the 8-bit data byte. The bus values are taken one system clock before the trailing edge was seen, while the strobe was still asserted.

Three qualifier levels are derived internally. The memory qualifier is the inverse of `mreqN`. The I/O qualifier is the inverse of `iorqN`. The refresh qualifier is `rfshN` as it is. A request ends when its qualifier falls. An optional filter input discards cycles in which the refresh qualifier was low, so DRAM refresh cycles do not fill the sample memory. A running count of emitted records is kept alongside.

Top module: `zbus_capture`

## Requirements
- R1: Status bit 0 of a record (recOut[24]) is the inverse of `wrN` as it was in the captured snapshot, so 1 marks a write.
- R2: Status bit 1 of a record (recOut[25]) equals the raw `iorqN` level of the captured snapshot.
- R3: Status bit 2 (recOut[26]) equals raw `rfshN`, and status bit 3 (recOut[27]) equals raw `m1N`, both from the captured snapshot.
- R4: A record is laid out as {status[3:0], address[15:0], data[7:0]}, with data in bits 7:0. The address and data come from the same snapshot as the status, which is the bus as sampled at the system clock edge just before the one that first samples the released strobe.
- R5: A record is emitted when `mreqN` or `iorqN` goes from low to high. `recValid` is high for exactly the one cycle that follows the second clock edge after the edge that first samples the high level.
- R6: When `mreqN` and `iorqN` rise at the same sampling edge, exactly one record is emitted.
- R7: With `refreshFilterEn` high at the emitting edge, a trailing edge whose snapshot has `rfshN` low produces no record. With it low, such cycles are captured.
- R8: `recCount` increases by one, modulo 2^CNT_W, in the same cycle each record is presented, and otherwise holds.
- R9: A synchronous active-high `rst` clears `recValid` and `recCount` and sets the edge history to "idle". No record appears after reset until a strobe has been sampled low and then high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| refreshFilterEn | input | 1 | 1 = drop cycles with refresh active |
| mreqN | input | 1 | Memory request, active low |
| iorqN | input | 1 | I/O request, active low |
| rfshN | input | 1 | Refresh, active low |
| m1N | input | 1 | Opcode fetch / acknowledge cycle, active low |
| wrN | input | 1 | Write strobe, active low |
| addrIn | input | 16 | CPU address bus |
| dataIn | input | 8 | CPU data bus |
| recValid | output | 1 | One-cycle strobe for a new record |
| recOut | output | 28 | {status, address, data} record |
| recCount | output | CNT_W | Running count of records |

## Verification
A wrong edge-history register appears at the ports as a missing, extra or doubled `recValid` pulse. This is visible within three clocks of the strobe release that should have produced it. A skewed snapshot register gives status, address or data fields that belong to a neighbouring clock. This shows in the first record after any bus transition inside a strobe window. A wrong synchronizer depth or reset value moves every pulse by a cycle, or creates a record right after reset. The per-cycle comparison against the reference model flags such a fault on the very next falling clock.

// File: rtl/zcap_pkg.sv
package zcap_pkg;
  parameter int ADDR_W = 16;
  parameter int DATA_W = 8;
  parameter int STAT_W = 4;
  localparam int REC_W = STAT_W + ADDR_W + DATA_W;

  typedef struct packed {
    logic              mreqN;
    logic              iorqN;
    logic              rfshN;
    logic              m1N;
    logic              wrN;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } busSnap_t;

  localparam busSnap_t SNAP_IDLE = '{mreqN: 1'b1, iorqN: 1'b1, rfshN: 1'b1,
                                     m1N: 1'b1, wrN: 1'b1, addr: '0, data: '0};

  typedef struct packed {
    logic capture;
  } capStrobe_t;
endpackage

// File: rtl/zcap_control.sv
module zcap_control
  import zcap_pkg::*;
(
  input  logic       filterEn,
  input  logic       currMreqN,
  input  logic       currIorqN,
  input  logic       prevMreqN,
  input  logic       prevIorqN,
  input  logic       prevRfshN,
  output capStrobe_t strobe
);
  logic memQualNow, memQualWas, ioQualNow, ioQualWas, rfshQual;
  logic memEnd, ioEnd, keep;

  always_comb begin
    // derived qualifier levels: memory and I/O inverted, refresh passed through
    memQualNow = ~currMreqN;
    memQualWas = ~prevMreqN;
    ioQualNow  = ~currIorqN;
    ioQualWas  = ~prevIorqN;
    rfshQual   = prevRfshN;
    memEnd = memQualWas & ~memQualNow;
    ioEnd  = ioQualWas & ~ioQualNow;
    keep   = ~filterEn | rfshQual;
    strobe.capture = (memEnd | ioEnd) & keep;
  end
endmodule

// File: rtl/zcap_datapath.sv
module zcap_datapath
  import zcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  busSnap_t         busIn,
  input  capStrobe_t       strobe,
  output logic             currMreqN,
  output logic             currIorqN,
  output logic             prevMreqN,
  output logic             prevIorqN,
  output logic             prevRfshN,
  output logic             recValid,
  output logic [REC_W-1:0] recOut,
  output logic [CNT_W-1:0] recCount
);
  localparam int LAST = SYNC_STAGES - 1;

  busSnap_t syncStage [SYNC_STAGES];
  busSnap_t prevSnap;
  logic [STAT_W-1:0] statusNib;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) syncStage[i] <= SNAP_IDLE;
        else     syncStage[i] <= busIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) syncStage[i] <= SNAP_IDLE;
        else     syncStage[i] <= syncStage[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prevSnap <= SNAP_IDLE;
    else     prevSnap <= syncStage[LAST];
  end

  assign currMreqN = syncStage[LAST].mreqN;
  assign currIorqN = syncStage[LAST].iorqN;
  assign prevMreqN = prevSnap.mreqN;
  assign prevIorqN = prevSnap.iorqN;
  assign prevRfshN = prevSnap.rfshN;

  // status nibble, LSB first: write (inverted), io, refresh, m1
  assign statusNib = {prevSnap.m1N, prevSnap.rfshN, prevSnap.iorqN, ~prevSnap.wrN};

  always_ff @(posedge clk) begin
    if (rst) begin
      recValid <= 1'b0;
      recOut   <= '0;
      recCount <= '0;
    end else begin
      recValid <= strobe.capture;
      if (strobe.capture) begin
        recOut   <= {statusNib, prevSnap.addr, prevSnap.data};
        recCount <= recCount + 1'b1;
      end
    end
  end
endmodule

// File: rtl/zbus_capture.sv
module zbus_capture
  import zcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                refreshFilterEn,
  input  logic                mreqN,
  input  logic                iorqN,
  input  logic                rfshN,
  input  logic                m1N,
  input  logic                wrN,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [DATA_W-1:0]   dataIn,
  output logic                recValid,
  output logic [REC_W-1:0]    recOut,
  output logic [CNT_W-1:0]    recCount
);
  busSnap_t   busIn;
  capStrobe_t strobe;
  logic currMreqN, currIorqN, prevMreqN, prevIorqN, prevRfshN;

  always_comb begin
    busIn.mreqN = mreqN;
    busIn.iorqN = iorqN;
    busIn.rfshN = rfshN;
    busIn.m1N   = m1N;
    busIn.wrN   = wrN;
    busIn.addr  = addrIn;
    busIn.data  = dataIn;
  end

  zcap_datapath #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .busIn(busIn), .strobe(strobe),
    .currMreqN(currMreqN), .currIorqN(currIorqN),
    .prevMreqN(prevMreqN), .prevIorqN(prevIorqN), .prevRfshN(prevRfshN),
    .recValid(recValid), .recOut(recOut), .recCount(recCount)
  );

  zcap_control u_ctl (
    .filterEn(refreshFilterEn),
    .currMreqN(currMreqN), .currIorqN(currIorqN),
    .prevMreqN(prevMreqN), .prevIorqN(prevIorqN), .prevRfshN(prevRfshN),
    .strobe(strobe)
  );
endmodule

// File: rtl/zbus_capture_chk.sv
module zbus_capture_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             refreshFilterEn,
  input logic             mreqN,
  input logic             iorqN,
  input logic             rfshN,
  input logic             m1N,
  input logic             wrN,
  input logic [15:0]      addrIn,
  input logic [7:0]       dataIn,
  input logic             recValid,
  input logic [27:0]      recOut,
  input logic [CNT_W-1:0] recCount
);
  AST_WRITE_BIT: assert property (@(posedge clk) disable iff (rst)
    recValid |-> recOut[24] == !$past(wrN, 4)); // R1
  AST_IO_BIT: assert property (@(posedge clk) disable iff (rst)
    recValid |-> recOut[25] == $past(iorqN, 4)); // R2
  AST_RFSH_M1_BITS: assert property (@(posedge clk) disable iff (rst)
    recValid |-> recOut[27:26] == {$past(m1N, 4), $past(rfshN, 4)}); // R3
  AST_ADDR_DATA: assert property (@(posedge clk) disable iff (rst)
    recValid |-> recOut[23:0] == {$past(addrIn, 4), $past(dataIn, 4)}); // R4
  AST_TRAILING_EDGE: assert property (@(posedge clk) disable iff (rst)
    recValid |-> (($past(mreqN, 3) && !$past(mreqN, 4)) ||
                  ($past(iorqN, 3) && !$past(iorqN, 4)))); // R5
  AST_REFRESH_DROP: assert property (@(posedge clk) disable iff (rst)
    (recValid && $past(refreshFilterEn)) |-> $past(rfshN, 4)); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (recValid && !$past(rst)) |-> recCount == CNT_W'($past(recCount) + 1'b1)); // R8
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!recValid && !$past(rst)) |-> $stable(recCount)); // R8
endmodule

bind zbus_capture zbus_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .refreshFilterEn(refreshFilterEn),
  .mreqN(mreqN), .iorqN(iorqN), .rfshN(rfshN), .m1N(m1N), .wrN(wrN),
  .addrIn(addrIn), .dataIn(dataIn),
  .recValid(recValid), .recOut(recOut), .recCount(recCount)
);

// File: tb/zbus_capture_tb.sv
module zbus_capture_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refreshFilterEn = 1'b0;
  logic mreqN = 1'b1, iorqN = 1'b1, rfshN = 1'b1, m1N = 1'b1, wrN = 1'b1;
  logic [15:0] addrIn = '0;
  logic [7:0]  dataIn = '0;
  logic        recValid;
  logic [27:0] recOut;
  logic [CNT_W-1:0] recCount;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  zbus_capture #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .refreshFilterEn(refreshFilterEn),
    .mreqN(mreqN), .iorqN(iorqN), .rfshN(rfshN), .m1N(m1N), .wrN(wrN),
    .addrIn(addrIn), .dataIn(dataIn),
    .recValid(recValid), .recOut(recOut), .recCount(recCount)
  );

  // reference model: a history of bus snapshots taken at each rising edge
  typedef struct {
    bit mq, io, rf, m1, wr;
    bit [15:0] a;
    bit [7:0]  d;
  } snap_t;

  snap_t hist[$];
  bit        expValid = 1'b0;
  bit [27:0] expRec   = '0;
  int        expCount = 0;

  function automatic snap_t idleSnap();
    snap_t s;
    s.mq = 1; s.io = 1; s.rf = 1; s.m1 = 1; s.wr = 1; s.a = 0; s.d = 0;
    return s;
  endfunction

  always @(posedge clk) begin
    snap_t now, older, oldest;
    bit ended;
    if (rst) begin
      hist.delete();
      for (int i = 0; i < 3; i++) hist.push_back(idleSnap());
      expValid = 0;
      expCount = 0;
    end else begin
      // hist[0] newest; hist[1] = bus two edges ago, hist[2] = three edges ago
      older  = hist[1];
      oldest = hist[2];
      ended  = (!oldest.mq && older.mq) || (!oldest.io && older.io);
      expValid = ended && (!refreshFilterEn || oldest.rf);
      if (expValid) begin
        expRec = {oldest.m1, oldest.rf, oldest.io, !oldest.wr, oldest.a, oldest.d};
        expCount = (expCount + 1) % (1 << CNT_W);
      end
      now.mq = mreqN; now.io = iorqN; now.rf = rfshN; now.m1 = m1N; now.wr = wrN;
      now.a = addrIn; now.d = dataIn;
      hist.push_front(now);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(recValid == expValid, "R5/R6/R7/R9 recValid", int'(recValid), int'(expValid));
      if (expValid && recValid) begin
        chk(recOut[24] == expRec[24], "R1 write bit", int'(recOut[24]), int'(expRec[24]));
        chk(recOut[25] == expRec[25], "R2 io bit", int'(recOut[25]), int'(expRec[25]));
        chk(recOut[27:26] == expRec[27:26], "R3 refresh/m1 bits",
            int'(recOut[27:26]), int'(expRec[27:26]));
        chk(recOut[23:0] == expRec[23:0], "R4 address/data",
            int'(recOut[23:0]), int'(expRec[23:0]));
      end
      chk(int'(recCount) == expCount, "R8 recCount", int'(recCount), expCount);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bus cycle: strobes low for len clocks, then released together
  task automatic busCycle(input bit mem, input bit io, input bit fetch, input bit wr,
                          input bit refr, input bit [15:0] a, input bit [7:0] d,
                          input int len);
    @(negedge clk);
    addrIn = a; dataIn = d; m1N = !fetch; wrN = !wr; rfshN = !refr;
    mreqN = !mem; iorqN = !io;
    idle(len);
    mreqN = 1; iorqN = 1;
    idle(1);
    m1N = 1; wrN = 1; rfshN = 1; addrIn = ~a; dataIn = ~d;
    idle(3);
  endtask

  int startCount;

  initial begin
    // R9: strobe held active across reset must not fire at reset release
    mreqN = 0;
    idle(4);
    chk(recValid == 0, "R9 reset valid", int'(recValid), 0);
    chk(recCount == 0, "R9 reset count", int'(recCount), 0);
    rst = 0;
    idle(3);
    mreqN = 1;
    idle(5);
    chk(int'(recCount) == 1, "R9 first record needs post-reset strobe", int'(recCount), 1);

    // R1..R5: opcode fetch, memory read, memory write, io read, io write
    busCycle(1, 0, 1, 0, 0, 16'h1234, 8'h3E, 3);
    busCycle(1, 0, 0, 0, 0, 16'hABCD, 8'h5A, 2);
    busCycle(1, 0, 0, 1, 0, 16'h8001, 8'hC3, 4);
    busCycle(0, 1, 0, 0, 0, 16'h00FE, 8'h77, 3);
    busCycle(0, 1, 0, 1, 0, 16'h00FF, 8'h81, 1);
    // R6: both requests released at once
    startCount = expCount;
    busCycle(1, 1, 0, 0, 0, 16'h4444, 8'h44, 2);
    chk(expCount == startCount + 1 && int'(recCount) == expCount,
        "R6 single record", int'(recCount), startCount + 1);
    // R7: refresh cycle captured with filter off, dropped with filter on
    startCount = int'(recCount);
    busCycle(1, 0, 0, 0, 1, 16'h007F, 8'h00, 2);
    chk(int'(recCount) == startCount + 1, "R7 refresh kept", int'(recCount), startCount + 1);
    refreshFilterEn = 1;
    startCount = int'(recCount);
    busCycle(1, 0, 0, 0, 1, 16'h0080, 8'h00, 2);
    chk(int'(recCount) == startCount, "R7 refresh dropped", int'(recCount), startCount);
    busCycle(1, 0, 1, 0, 0, 16'h2000, 8'h11, 2);
    chk(int'(recCount) == startCount + 1, "R7 normal kept with filter", int'(recCount),
        startCount + 1);

    // randomized traffic, including filter toggles and glitchy strobes
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      mreqN = ($urandom_range(0, 2) != 0) ? ~mreqN : mreqN;
      iorqN = ($urandom_range(0, 3) == 0) ? ~iorqN : iorqN;
      rfshN = $urandom_range(0, 3) != 0;
      m1N   = $urandom_range(0, 1) != 0;
      wrN   = $urandom_range(0, 1) != 0;
      addrIn = 16'($urandom);
      dataIn = 8'($urandom);
      if ($urandom_range(0, 40) == 0) refreshFilterEn = ~refreshFilterEn;
    end
    mreqN = 1; iorqN = 1;
    idle(6);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule